// File: doc/BRIEF.md
# Video Frame Capture Write Controller

This block turns a one-bit video stream into bytes and writes one whole frame of them into a byte-wide synchronous RAM. Its inputs are the output of an external level comparator (a high level marks a dark pixel), a frame sync pulse and a line sync pulse. A pixel-rate enable is derived from the capture clock. Each pixel tick shifts one comparator sample into a byte accumulator. Every eighth sample produces one RAM write.

The host requests a capture by pulling its MODE line low. That line is synchronised into the capture clock domain with two flops. Recording does not begin at that point. It begins on the next frame sync edge, where READY drops and the write address returns to zero. Each line sync moves the address to a fresh 64-byte row, so every video line lands at a row-aligned location. The frame sync edge after that ends the capture and raises READY again. Reading the stored frame back is the job of a separate block.

Top module: `vid_frame_capture`

## Requirements
- R1: After reset, `ready` is 1 and `wr_en` is 0.
- R2: The block arms only when MODE, after its two-flop synchroniser, is seen low while the block is idle. A frame sync that arrives while the block is not armed causes no write, and `ready` stays 1.
- R3: The first frame sync rising edge after arming starts recording. `ready` reads 0 in the cycle after that edge, and the write address is cleared to 0.
- R4: While recording, `cmp_in` is sampled once every PIX_DIV clocks. The first sample is taken in the cycle after a start or line sync edge. Samples are packed MSB first, so the first of eight ends in bit 7 of the byte. A stored 1 means a dark pixel.
- R5: The clock edge that takes the eighth sample of a byte is followed by exactly one cycle with `wr_en` = 1. In that cycle `wr_data` holds the byte and `wr_addr` holds the current address. The address then increases by 1.
- R6: A line sync rising edge during recording moves the address to the next multiple of 64 that is strictly above the current address. It also restarts the pixel phase and the bit count, and any partial byte is discarded.
- R7: The next frame sync rising edge ends recording. `ready` returns to 1 in the following cycle, the partial byte is dropped, and no further writes occur until the block is armed again.
- R8: No write is issued at an address of 24576 or above. The address saturates at 24576.
- R9: The sync inputs act only on rising edges. A sync held high for many cycles counts once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Capture clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_in | input | 1 | Host arm request, asynchronous, active low |
| cmp_in | input | 1 | Comparator output, 1 = dark |
| frame_sync | input | 1 | Frame sync pulse, synchronous |
| line_sync | input | 1 | Line sync pulse, synchronous |
| ready | output | 1 | 1 when not recording |
| wr_en | output | 1 | RAM write strobe |
| wr_addr | output | 15 | RAM write address |
| wr_data | output | 8 | RAM write data |

## Verification
The comparator is driven with four patterns:
- All-ones and all-zeros, which expose inverted or stuck bits.
- A per-pixel alternating pattern, which exposes an off-by-one in the sampling phase.
- A pseudo-random stream, which exposes bit-order and packing errors.

Line lengths are chosen so that some lines are not a whole number of bytes, which checks that partial bytes are discarded. One line runs past 64 bytes, which checks the row crossing. One line sync is held high for many cycles, which checks edge-only detection. A frame sync sent before arming checks that unarmed syncs are ignored. A final frame with about 390 short lines drives the address into its saturation limit.

// File: rtl/vfc_pkg.sv
package vfc_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARMED = 2'd1,
    ST_REC   = 2'd2
  } cap_state_e;

  // Next row start strictly above a, clamped to the store size.
  function automatic int unsigned next_row(input int unsigned a,
                                           input int unsigned row,
                                           input int unsigned lim);
    int unsigned n;
    n = (a / row + 1) * row;
    return (n > lim) ? lim : n;
  endfunction

  // Byte step with saturation at the store size.
  function automatic int unsigned sat_inc(input int unsigned a,
                                          input int unsigned lim);
    return (a >= lim) ? lim : a + 1;
  endfunction

  function automatic logic below_limit(input int unsigned a,
                                       input int unsigned lim);
    return a < lim;
  endfunction

endpackage

// File: rtl/vfc_mode_sync.sv
module vfc_mode_sync #(
  parameter logic RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic q_sync
);
  logic stage1, stage2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= RESET_VAL;
      stage2 <= RESET_VAL;
    end else begin
      stage1 <= d_async;
      stage2 <= stage1;
    end
  end

  assign q_sync = stage2;
endmodule

// File: rtl/vfc_ctrl.sv
module vfc_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic mode_s,
  input  logic fs_evt,
  output logic rec,
  output logic start,
  output logic ready
);
  import vfc_pkg::*;

  cap_state_e state, state_nx;

  always_comb begin
    state_nx = state;
    case (state)
      ST_IDLE:  if (!mode_s) state_nx = ST_ARMED;
      ST_ARMED: if (fs_evt)  state_nx = ST_REC;
      ST_REC:   if (fs_evt)  state_nx = ST_IDLE;
      default:               state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= state_nx;
  end

  assign rec   = (state == ST_REC);
  assign start = (state == ST_ARMED) && fs_evt;
  assign ready = (state != ST_REC);

  // R2: arming only follows a low synchronised MODE
  p_arm_needs_mode_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(state) == ST_IDLE && state == ST_ARMED) |-> !$past(mode_s));

  // R3: READY only falls after a frame sync edge
  p_ready_fall_on_frame_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ready) |-> $past(fs_evt));

  // R7: READY only rises after a frame sync edge
  p_ready_rise_on_frame_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> $past(fs_evt));
endmodule

// File: rtl/vfc_pix_shifter.sv
module vfc_pix_shifter #(
  parameter int unsigned PIX_DIV = 2,
  parameter int unsigned BYTE_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rec,
  input  logic              restart,
  input  logic              cmp_in,
  output logic              pix_tick,
  output logic              byte_done,
  output logic [BYTE_W-1:0] byte_val
);
  localparam int unsigned DIV_W = (PIX_DIV > 1) ? $clog2(PIX_DIV) : 1;
  localparam int unsigned CNT_W = $clog2(BYTE_W);
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(PIX_DIV - 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BYTE_W - 1);

  logic [DIV_W-1:0]  div_q;
  logic [CNT_W-1:0]  bit_q;
  logic [BYTE_W-1:0] sreg_q;

  assign pix_tick  = rec && !restart && (div_q == '0);
  assign byte_done = pix_tick && (bit_q == CNT_LAST);
  assign byte_val  = {sreg_q[BYTE_W-2:0], cmp_in};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q  <= '0;
      bit_q  <= '0;
      sreg_q <= '0;
    end else if (restart) begin
      div_q <= '0;
      bit_q <= '0;
    end else if (rec) begin
      div_q <= (div_q == DIV_LAST) ? '0 : div_q + 1'b1;
      if (pix_tick) begin
        sreg_q <= byte_val;
        bit_q  <= (bit_q == CNT_LAST) ? '0 : bit_q + 1'b1;
      end
    end
  end

  generate
    if (PIX_DIV > 1) begin : g_spacing
      // R4: pixel ticks are never back to back when dividing
      p_pixel_spacing_r4: assert property (@(posedge clk) disable iff (!rst_n)
        pix_tick |=> !pix_tick);
    end
  endgenerate
endmodule

// File: rtl/vfc_addr_gen.sv
module vfc_addr_gen #(
  parameter int unsigned ADDR_W    = 15,
  parameter int unsigned ROW_BYTES = 64,
  parameter int unsigned MEM_BYTES = 24576,
  parameter int unsigned BYTE_W    = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rec,
  input  logic              start,
  input  logic              row_evt,
  input  logic              byte_done,
  input  logic [BYTE_W-1:0] byte_val,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [BYTE_W-1:0] wr_data
);
  localparam int unsigned ROW_LSB = $clog2(ROW_BYTES);

  logic [ADDR_W-1:0] cur_addr;
  logic              wen_q;
  logic [ADDR_W-1:0] waddr_q;
  logic [BYTE_W-1:0] hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_addr <= '0;
      wen_q    <= 1'b0;
      waddr_q  <= '0;
      hold_q   <= '0;
    end else begin
      wen_q <= 1'b0;
      if (start) begin
        cur_addr <= '0;
      end else if (row_evt) begin
        cur_addr <= ADDR_W'(vfc_pkg::next_row(32'(cur_addr), ROW_BYTES, MEM_BYTES));
      end else if (byte_done) begin
        hold_q   <= byte_val;
        waddr_q  <= cur_addr;
        wen_q    <= vfc_pkg::below_limit(32'(cur_addr), MEM_BYTES);
        cur_addr <= ADDR_W'(vfc_pkg::sat_inc(32'(cur_addr), MEM_BYTES));
      end
    end
  end

  assign wr_en   = wen_q;
  assign wr_addr = waddr_q;
  assign wr_data = hold_q;

  // R8: writes stay inside the store
  p_write_in_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (32'(wr_addr) < MEM_BYTES));

  // R6: a line sync leaves the address on a row boundary
  p_row_aligned_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(row_evt) |-> (cur_addr[ROW_LSB-1:0] == '0));

  // R3: start clears the address
  p_start_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $past(start) |-> (cur_addr == '0));

  // R7: a write strobe only follows a recording cycle
  p_write_only_recording_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> $past(rec));
endmodule

// File: rtl/vid_frame_capture.sv
module vid_frame_capture #(
  parameter int unsigned ADDR_W    = 15,
  parameter int unsigned ROW_BYTES = 64,
  parameter int unsigned MEM_BYTES = 24576,
  parameter int unsigned PIX_DIV   = 2,
  parameter int unsigned BYTE_W    = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_in,
  input  logic              cmp_in,
  input  logic              frame_sync,
  input  logic              line_sync,
  output logic              ready,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [BYTE_W-1:0] wr_data
);
  logic fs_q, ls_q;
  logic fs_evt, ls_evt;
  logic mode_s, rec, start, restart, row_evt;
  logic pix_tick, byte_done;
  logic [BYTE_W-1:0] byte_val;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fs_q <= 1'b0;
      ls_q <= 1'b0;
    end else begin
      fs_q <= frame_sync;
      ls_q <= line_sync;
    end
  end

  assign fs_evt  = frame_sync && !fs_q;
  assign ls_evt  = line_sync && !ls_q;
  assign restart = start || (rec && (fs_evt || ls_evt));
  assign row_evt = rec && ls_evt && !fs_evt;

  vfc_mode_sync #(.RESET_VAL(1'b1)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_async(mode_in), .q_sync(mode_s));

  vfc_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .mode_s(mode_s), .fs_evt(fs_evt),
    .rec(rec), .start(start), .ready(ready));

  vfc_pix_shifter #(.PIX_DIV(PIX_DIV), .BYTE_W(BYTE_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .rec(rec), .restart(restart), .cmp_in(cmp_in),
    .pix_tick(pix_tick), .byte_done(byte_done), .byte_val(byte_val));

  vfc_addr_gen #(.ADDR_W(ADDR_W), .ROW_BYTES(ROW_BYTES), .MEM_BYTES(MEM_BYTES),
                 .BYTE_W(BYTE_W)) u_addr (
    .clk(clk), .rst_n(rst_n), .rec(rec), .start(start), .row_evt(row_evt),
    .byte_done(byte_done), .byte_val(byte_val),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data));

  // R9: a held sync yields no second event
  p_sync_edge_only_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(line_sync) && line_sync) |-> !ls_evt);

  // R4: no pixel is taken outside recording
  p_no_tick_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    pix_tick |-> !ready);
endmodule

// File: tb/tb_vid_frame_capture.sv
module tb_vid_frame_capture;
  localparam int DIV = 2;
  localparam int LIM = 24576;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mode_in = 1'b1, cmp_in = 1'b0, frame_sync = 1'b0, line_sync = 1'b0;
  logic ready, wr_en;
  logic [14:0] wr_addr;
  logic [7:0]  wr_data;

  vid_frame_capture dut (
    .clk(clk), .rst_n(rst_n), .mode_in(mode_in), .cmp_in(cmp_in),
    .frame_sync(frame_sync), .line_sync(line_sync), .ready(ready),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data));

  always #2 clk = ~clk;

  int checks = 0, fails = 0;
  int wr_count = 0, max_addr = -1;
  bit done = 0;
  logic [15:0] lfsr = 16'hACE1;

  // behavioural reference state
  int m1, m2, st, addr, ph, nb, acc;
  bit fsp, lsp, e_wen;
  int e_addr, e_data;

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m1 = 1; m2 = 1; st = 0; addr = 0; ph = 0; nb = 0; acc = 0;
      fsp = 0; lsp = 0; e_wen = 0; e_addr = 0; e_data = 0;
    end else begin
      bit fe, le;
      int cur;
      fe = frame_sync && !fsp;
      le = line_sync && !lsp;
      fsp = frame_sync; lsp = line_sync;
      cur = m2; m2 = m1; m1 = int'(mode_in);
      e_wen = 0;
      if (st == 0) begin
        if (cur == 0) st = 1;
      end else if (st == 1) begin
        if (fe) begin st = 2; addr = 0; ph = 0; nb = 0; end
      end else begin
        if (fe) st = 0;
        else if (le) begin
          addr = ((addr / 64) + 1) * 64;
          if (addr > LIM) addr = LIM;
          ph = 0; nb = 0;
        end else begin
          if (ph == 0) begin
            acc = ((acc << 1) | int'(cmp_in)) & 255;
            nb++;
            if (nb == 8) begin
              nb = 0;
              e_addr = addr; e_data = acc;
              e_wen = (addr < LIM);
              if (addr < LIM) addr++;
            end
          end
          ph = (ph + 1) % DIV;
        end
      end
    end
  end

  // per-cycle comparison against the reference
  always @(negedge clk) begin
    if (rst_n) begin
      chk(ready === (st != 2), "R3", "ready", int'(ready), int'(st != 2));
      chk(wr_en === e_wen, "R5", "wr_en", int'(wr_en), int'(e_wen));
      if (e_wen && wr_en) begin
        chk(int'(wr_addr) == e_addr, "R6", "wr_addr", int'(wr_addr), e_addr);
        chk(int'(wr_data) == e_data, "R4", "wr_data", int'(wr_data), e_data);
      end
      if (wr_en) begin
        wr_count++;
        if (int'(wr_addr) > max_addr) max_addr = int'(wr_addr);
      end
    end
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic run_line(int cycles, int pat);
    for (int i = 0; i < cycles; i++) begin
      case (pat)
        0: cmp_in = 1'b0;
        1: cmp_in = 1'b1;
        2: cmp_in = ((i / DIV) % 2) == 1;
        default: begin
          lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
          cmp_in = lfsr[0];
        end
      endcase
      step(1);
    end
  endtask

  task automatic line_pulse(int w);
    line_sync = 1'b1; step(w); line_sync = 1'b0;
  endtask

  task automatic frame_pulse(int w);
    frame_sync = 1'b1; step(w); frame_sync = 1'b0;
  endtask

  task automatic arm_and_start();
    mode_in = 1'b0;
    step(6);
    frame_pulse(3);
    chk(ready == 1'b0, "R3", "ready after start", int'(ready), 0);
    mode_in = 1'b1;
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int saved;
    step(5);
    chk(ready == 1'b1, "R1", "ready at reset", int'(ready), 1);
    chk(wr_en == 1'b0, "R1", "wr_en at reset", int'(wr_en), 0);
    rst_n = 1'b1;
    step(3);

    // R2: unarmed frame sync is ignored
    frame_pulse(2);
    run_line(100, 1);
    chk(ready == 1'b1, "R2", "ready unarmed", int'(ready), 1);
    chk(wr_count == 0, "R2", "writes unarmed", wr_count, 0);

    // main frame with several patterns
    arm_and_start();
    run_line(200, 1);
    line_pulse(2);
    run_line(300, 0);
    line_pulse(40);          // R9 long pulse
    run_line(1100, 2);       // more than 64 bytes: crosses a row
    line_pulse(1);
    run_line(501, 3);        // ends with a partial byte
    frame_pulse(2);
    step(20);
    chk(ready == 1'b1, "R7", "ready after stop", int'(ready), 1);
    saved = wr_count;
    line_pulse(1);
    run_line(200, 1);
    chk(wr_count == saved, "R7", "writes after stop", wr_count, saved);

    // R8: saturation frame
    arm_and_start();
    for (int k = 0; k < 390; k++) begin
      run_line(20, 3);
      line_pulse(1);
    end
    frame_pulse(2);
    step(10);
    chk(max_addr < LIM, "R8", "max write address", max_addr, LIM - 1);
    chk(max_addr >= LIM - 64, "R8", "last row reached", max_addr, LIM - 64);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule